// File: doc/BRIEF.md
# One-Time-Programmable Configuration Register Commit Controller

This block guards a bank of eleven configuration words kept in nonvolatile storage: four read-protection words, four program-protection words, two user words and one debug word. Software picks a target by writing an address code, optionally writes a data word, then sends a keyed command to the control register. The block checks the key, resolves the target, and holds a busy flag for a fixed programming time. At the end it merges the new value into storage. A merge can only clear bits.

Read-protection, program-protection and user words each have a working copy that software can read and write. The setting takes effect at once, so it can be tried before it is burned in. A commit to one of these targets stores the working copy. A commit to the debug word stores the data register. The user and debug words can be programmed only once: bit 31 of each stored word marks it as still unprogrammed. The protection words can be committed any number of times.

The nonvolatile cells are modelled as flops. A power-on reset sets them to the erased pattern of all ones. A separate system reset restarts the controller and reloads every working copy from storage.

Top module: `nvreg_commit_ctl`

## Requirements
- R1: A commit starts only on a control write (selector 2) whose bits 31:16 equal the key 0xA442 and whose bit 3 is 1. Any other control write starts nothing.
- R2: The address register (selector 0) chooses the target. Read-protect words 0..3 use codes 0x0, 0x2, 0x4, 0x8. Program-protect words 0..3 use codes 0x1, 0x3, 0x5, 0x7. User word 0 uses 0x80000000, user word 1 uses 0x80000001, and the debug word uses 0x75100000. A commit changes only the chosen stored word.
- R3: A debug commit takes its value from the data register (selector 1). Every other target takes the value of its own working copy, and the data register has no effect on it.
- R4: Working copies are read and written immediately at these selectors: read-protect 0..3 at 4..7, program-protect 0..3 at 8..11, user 0 and user 1 at 12 and 13. Stored words are read at 16 + target index. The target index is 0..3 for read-protect, 4..7 for program-protect, 8 and 9 for the user words, and 10 for the debug word.
- R5: A finished commit stores the old stored value ANDed with the supplied value. No stored bit ever returns from 0 to 1.
- R6: A commit to user 0, user 1 or debug is accepted only while bit 31 of that stored word is 1. Otherwise the commit leaves storage unchanged.
- R7: A protection word accepts repeated commits, each one ANDed into storage.
- R8: Control bit 3 reads 1 for exactly PROG_CYCLES cycles after an accepted commit, then clears by itself.
- R9: Control writes carrying the key with erase (bit 1) or mass-erase (bit 2) set, but with bit 3 clear, change no stored word.
- R10: Control writes that arrive while busy are ignored, even if they carry a valid commit command.
- R11: A commit to an unmatched address code, or to a locked one-time word, does not go busy and sets a sticky error flag (selector 3, bit 0). Writing 1 to that bit clears the flag. Writing 0 leaves it set.
- R12: Power-on reset sets all stored words and working copies to 0xFFFFFFFF. System reset reloads each working copy from its stored word and leaves storage untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; erases storage |
| rst_n | input | 1 | System reset, active low, synchronous; reloads working copies |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 5 | Register selector for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_sel, combinational |

## Verification
The bench builds the block with PROG_CYCLES set to 4. This keeps each commit short, so a run can make many commits in sequence: all eleven targets, repeated protection merges, and second attempts on the one-time words. It also places a command issued during a commit well inside the busy window. The key keeps its default value, so the bench exercises exactly the keyed and near-miss control words that software would use.

// File: rtl/nvreg_commit_ctl.sv
module nvreg_commit_ctl #(
  parameter int          PROG_CYCLES = 64,
  parameter logic [15:0] COMMIT_KEY  = 16'hA442
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int CW      = $clog2(PROG_CYCLES + 1);
  localparam int NT      = 11;
  localparam int NW      = 10;
  localparam int DBG_IDX = 10;
  localparam logic [4:0] SEL_ADDR = 5'd0, SEL_DATA = 5'd1, SEL_CTRL = 5'd2, SEL_STAT = 5'd3;
  localparam logic [4:0] SEL_WK = 5'd4, SEL_NV = 5'd16;

  logic [31:0] nv [NT];
  logic [31:0] wk [NW];
  logic [31:0] addr_q, data_q, val_q, src;
  logic [3:0]  tgt_q, idx;
  logic [CW-1:0] cnt_q;
  logic busy_q, err_q, hit, locked;

  always_comb begin
    hit = 1'b1;
    idx = 4'd0;
    case (addr_q)
      32'h0000_0000: idx = 4'd0;
      32'h0000_0002: idx = 4'd1;
      32'h0000_0004: idx = 4'd2;
      32'h0000_0008: idx = 4'd3;
      32'h0000_0001: idx = 4'd4;
      32'h0000_0003: idx = 4'd5;
      32'h0000_0005: idx = 4'd6;
      32'h0000_0007: idx = 4'd7;
      32'h8000_0000: idx = 4'd8;
      32'h8000_0001: idx = 4'd9;
      32'h7510_0000: idx = 4'd10;
      default:       hit = 1'b0;
    endcase
  end

  always_comb begin
    src    = data_q;
    locked = 1'b0;
    for (int i = 0; i < NT; i++) begin
      if (idx == 4'(i)) begin
        if (i < NW) src = wk[i < NW ? i : 0];
        if (i >= 8) locked = ~nv[i][31];
      end
    end
  end

  wire ctrl_wr = reg_we && reg_sel == SEL_CTRL;
  wire go      = ctrl_wr && !busy_q && reg_wdata[31:16] == COMMIT_KEY && reg_wdata[3];
  wire accept  = go && hit && !locked;
  wire done    = busy_q && cnt_q == '0;

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      val_q  <= '0;
      tgt_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (reg_we && reg_sel == SEL_ADDR) addr_q <= reg_wdata;
      if (reg_we && reg_sel == SEL_DATA) data_q <= reg_wdata;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(PROG_CYCLES - 1);
        tgt_q  <= idx;
        val_q  <= src;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (go && !accept) err_q <= 1'b1;
      else if (reg_we && reg_sel == SEL_STAT && reg_wdata[0]) err_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_nv
    always_ff @(posedge clk) begin
      if (!por_n) nv[i] <= '1;
      else if (done && tgt_q == 4'(i)) nv[i] <= nv[i] & val_q;
    end

    a_r5_clear_only: assert property (@(posedge clk) disable iff (!por_n)
      1'b1 |=> ((nv[i] & ~$past(nv[i])) == 32'h0));
  end

  for (genvar i = 0; i < NW; i++) begin : g_wk
    always_ff @(posedge clk) begin
      if (!por_n) wk[i] <= '1;
      else if (!rst_n) wk[i] <= nv[i];
      else if (reg_we && reg_sel == SEL_WK + 5'(i)) wk[i] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ADDR: reg_rdata = addr_q;
      SEL_DATA: reg_rdata = data_q;
      SEL_CTRL: reg_rdata = {28'h0, busy_q, 3'b000};
      SEL_STAT: reg_rdata = {31'h0, err_q};
      default: begin
        for (int i = 0; i < NW; i++)
          if (reg_sel == SEL_WK + 5'(i)) reg_rdata = wk[i];
        for (int i = 0; i < NT; i++)
          if (reg_sel == SEL_NV + 5'(i)) reg_rdata = nv[i];
      end
    endcase
  end

  a_r1_key_gate: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(busy_q) |-> $past(ctrl_wr && reg_wdata[31:16] == COMMIT_KEY && reg_wdata[3]));

  a_r6_locked_rejected: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (go && hit && locked) |=> (err_q && !busy_q));

  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);

  a_r8_busy_ends: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    done |=> !busy_q);

  a_r10_busy_latch: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (busy_q && !done) |=> ($stable(tgt_q) && $stable(val_q)));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (err_q && !(reg_we && reg_sel == SEL_STAT && reg_wdata[0])) |=> err_q);
endmodule

// File: tb/nvreg_commit_ctl_tb_top.sv
module nvreg_commit_ctl_tb_top;
  localparam int PC = 4;
  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [4:0] sel = '0;
  logic [31:0] wd = '0, rdata;
  int nchk = 0, nfail = 0;
  logic [31:0] exp_nv [11];
  logic [31:0] codes [11] = '{32'h0, 32'h2, 32'h4, 32'h8, 32'h1, 32'h3, 32'h5, 32'h7,
                              32'h8000_0000, 32'h8000_0001, 32'h7510_0000};

  always #4 clk = ~clk;

  nvreg_commit_ctl #(.PROG_CYCLES(PC)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_we(we),
    .reg_sel(sel), .reg_wdata(wd), .reg_rdata(rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] s, input logic [31:0] d);
    @(negedge clk); we = 1'b1; sel = s; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] s, output logic [31:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic chk_store(input string req);
    logic [31:0] v;
    for (int i = 0; i < 11; i++) begin
      rd(5'(16 + i), v);
      chk(req, v, exp_nv[i]);
    end
  endtask

  task automatic commit(input logic [31:0] code, input int exp_busy);
    logic [31:0] v;
    int n = 0;
    wr(5'd0, code);
    wr(5'd2, 32'hA442_0008);
    rd(5'd2, v);
    while (v[3] && n < 50) begin
      n++;
      @(negedge clk);
      rd(5'd2, v);
    end
    chk("R8 busy cycles", 32'(n), 32'(exp_busy));
  endtask

  task automatic t_reset;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    for (int i = 0; i < 11; i++) exp_nv[i] = '1;
    chk_store("R12 erased storage");
    for (int i = 0; i < 10; i++) begin
      rd(5'(4 + i), v);
      chk("R12 erased working", v, '1);
    end
    rd(5'd2, v); chk("R12 ctrl idle", v, 32'h0);
    rd(5'd3, v); chk("R12 err clear", v, 32'h0);
  endtask

  task automatic t_working;
    logic [31:0] v;
    for (int i = 0; i < 10; i++) wr(5'(4 + i), 32'hC0DE_0000 | 32'(i));
    for (int i = 0; i < 10; i++) begin
      rd(5'(4 + i), v);
      chk("R4 working copy", v, 32'hC0DE_0000 | 32'(i));
    end
    for (int i = 0; i < 10; i++) wr(5'(4 + i), '1);
  endtask

  task automatic t_key;
    logic [31:0] v;
    wr(5'd4, 32'h0);
    wr(5'd0, 32'h0);
    wr(5'd2, 32'h1234_0008);
    rd(5'd2, v); chk("R1 wrong key", v, 32'h0);
    wr(5'd2, 32'hA442_0000);
    rd(5'd2, v); chk("R1 no commit bit", v, 32'h0);
    wr(5'd2, 32'hA442_0002);
    wr(5'd2, 32'hA442_0004);
    wr(5'd2, 32'hA442_0006);
    repeat (PC + 2) @(negedge clk);
    chk_store("R9 erase ignored");
    rd(5'd3, v); chk("R1 no error", v, 32'h0);
    wr(5'd4, '1);
  endtask

  task automatic t_prot;
    logic [31:0] p;
    for (int i = 0; i < 8; i++) begin
      p = ~(32'h7 << (i * 3));
      wr(5'(4 + i), p);
      wr(5'd1, 32'h0);
      commit(codes[i], PC);
      exp_nv[i] = exp_nv[i] & p;
      chk_store("R2 R3 protection target");
    end
    wr(5'd6, ~32'hF000_0000);
    commit(codes[2], PC);
    exp_nv[2] = exp_nv[2] & ~32'hF000_0000;
    chk_store("R7 repeated commit");
    wr(5'd9, '1);
    commit(codes[5], PC);
    chk_store("R5 no bit set");
  endtask

  task automatic t_once;
    logic [31:0] v;
    wr(5'd12, 32'h7FFF_00FF);
    commit(codes[8], PC);
    exp_nv[8] = 32'h7FFF_00FF;
    chk_store("R6 user0 first");
    wr(5'd12, 32'h7000_0000);
    commit(codes[8], 0);
    chk_store("R6 user0 locked");
    rd(5'd3, v); chk("R11 locked error", v, 32'h1);
    wr(5'd3, 32'h0);
    rd(5'd3, v); chk("R11 write 0 keeps", v, 32'h1);
    wr(5'd3, 32'h1);
    rd(5'd3, v); chk("R11 w1c", v, 32'h0);
    wr(5'd13, 32'hFFFF_FF00);
    commit(codes[9], PC);
    wr(5'd13, 32'h0F0F_0F0F);
    commit(codes[9], PC);
    exp_nv[9] = 32'h0F0F_0F00;
    chk_store("R6 user1 open until bit31");
    commit(codes[9], 0);
    chk_store("R6 user1 locked");
    wr(5'd1, 32'h1234_5678);
    commit(codes[10], PC);
    exp_nv[10] = 32'h1234_5678;
    chk_store("R3 debug from data");
    wr(5'd1, 32'h0);
    commit(codes[10], 0);
    chk_store("R6 debug locked");
    wr(5'd3, 32'h1);
  endtask

  task automatic t_badaddr;
    logic [31:0] v;
    commit(32'h6, 0);
    rd(5'd3, v); chk("R11 unmatched error", v, 32'h1);
    wr(5'd3, 32'h1);
    commit(32'h8000_0002, 0);
    rd(5'd3, v); chk("R11 unmatched error 2", v, 32'h1);
    chk_store("R11 no storage change");
    wr(5'd3, 32'h1);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    int n = 0;
    wr(5'd7, 32'hFFFF_0000);
    wr(5'd11, 32'h0);
    wr(5'd0, codes[3]);
    wr(5'd2, 32'hA442_0008);
    wr(5'd0, codes[7]);
    wr(5'd2, 32'hA442_0008);
    rd(5'd2, v);
    while (v[3] && n < 50) begin
      n++;
      @(negedge clk);
      rd(5'd2, v);
    end
    exp_nv[3] = exp_nv[3] & 32'hFFFF_0000;
    chk_store("R10 busy write ignored");
    rd(5'd3, v); chk("R10 no error", v, 32'h0);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    wr(5'd4, 32'hAAAA_AAAA);
    wr(5'd12, 32'h0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      rd(5'(4 + i), v);
      chk("R12 reload working", v, exp_nv[i]);
    end
    chk_store("R12 storage kept");
  endtask

  initial begin
    t_reset();
    t_working();
    t_key();
    t_prot();
    t_once();
    t_badaddr();
    t_busy();
    t_reload();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule